// File: doc/BRIEF.md
# Cache capacity allocation controller

This block is the register front end of a cache capacity QoS controller. For every resource control ID it keeps a capacity block mask: one bit per capacity block, where a set bit means the ID may allocate into that block. When the build enables code/data separation, each ID holds two masks, one for data fetches and one for instruction fetches. The cache way-enforcement logic elsewhere consumes these masks.

Software reaches the block through a 64-bit register window. A read-only word reports the version and the number of capacity blocks. A staging word holds a mask in flight. A control word launches commands. A command either copies the staging mask into the table entry chosen by the ID and access-type fields, or copies that entry back into staging.

Each command runs for a fixed number of cycles. During that time a busy flag is raised. When the flag drops, a status code reports the outcome.

Top module: `cc_alloc_ctrl`

## Requirements
- R1: The word at byte offset 0x00 reads minor version in bits 3:0, major version in bits 7:4, the capacity block count NCBLKS in bits 23:8, and zero above. Writes to it have no effect.
- R2: The control word at offset 0x18 holds OP in bits 4:0, AT in bits 7:5 and RCID in bits 19:8. Bits 31:20 and 63:40 read back the last value written to them. STATUS (bits 38:32) and BUSY (bit 39) cannot be written by software.
- R3: OP=1 copies the staging mask into the table entry for (RCID, AT) and finishes with STATUS=1.
- R4: OP=2 copies the table entry for (RCID, AT) into the staging word and finishes with STATUS=1.
- R5: STATUS reads 0 after reset. BUSY reads 1 for exactly CMD_LAT cycles, starting with the cycle after the launching write. STATUS and the staging result are valid in the first cycle in which BUSY reads 0.
- R6: While BUSY is 1, writes to the control word and to the staging word are ignored.
- R7: A command with an undefined OP (anything other than 1 or 2), with RCID at or above NUM_RCID, or with AT above 1 on a split build finishes with STATUS=2 and leaves the table and the staging word unchanged.
- R8: Writing OP=0 launches nothing. BUSY stays 0, STATUS keeps its previous value, and the other control fields are still updated.
- R9: On a split build, AT=0 selects the data half and AT=1 the code half; the two halves are independent, and the written AT value reads back. On a unified build, AT always reads 0 and every command acts on one mask shared by both access types.
- R10: The staging word lives at offset 0x20. Bits at or above NCBLKS read 0, including all of bits 63:32.
- R11: Reset sets every table entry to all ones across NCBLKS bits, and clears the staging word to 0.
- R12: Reads from any other offset (for example 0x08, 0x10 or 0x28) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data; combinational, valid while req_i=1 and we_i=0, else 0 |

## Verification
The bench builds two instances side by side.

The first is a split build with 16 IDs, 20 capacity blocks and a four-cycle command latency. Because the block count is below 32, staging bits 31:20 can be shown to read zero. The four-cycle latency leaves room to hit the block with control and staging writes while BUSY is still high.

The second is a unified build with 5 IDs, 8 blocks and a one-cycle latency. Its ID count is not a power of two, so IDs 5 to 7 fall inside the index width yet must still be rejected. It also exercises the shortest possible busy window and shows the code and data views collapsing onto one mask.

// File: rtl/cc_alloc_pkg.sv
package cc_alloc_pkg;

  localparam logic [4:0] OP_NOP    = 5'd0;
  localparam logic [4:0] OP_CONFIG = 5'd1;
  localparam logic [4:0] OP_READ   = 5'd2;

  localparam logic [6:0] ST_NONE = 7'd0;
  localparam logic [6:0] ST_OK   = 7'd1;
  localparam logic [6:0] ST_BAD  = 7'd2;

  localparam logic [7:0] OFF_CAPS  = 8'h00;
  localparam logic [7:0] OFF_CTL   = 8'h18;
  localparam logic [7:0] OFF_STAGE = 8'h20;

  typedef struct packed {
    logic [11:0] rcid;
    logic [2:0]  at;
    logic [4:0]  op;
  } cmd_t;

endpackage

// File: rtl/cc_cmd_fsm.sv
module cc_cmd_fsm
  import cc_alloc_pkg::*;
#(
  parameter int unsigned CMD_LAT  = 4,
  parameter int unsigned NUM_RCID = 16,
  parameter bit          SPLIT_AT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       launch_i,
  input  cmd_t       cmd_i,
  output logic       busy_o,
  output logic [6:0] status_o,
  output logic       tbl_we_o,
  output logic       stage_ld_o
);

  localparam int unsigned CNT_W = (CMD_LAT > 1) ? $clog2(CMD_LAT) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       status_q;
  logic             done;
  logic             legal;

  assign legal = ((cmd_i.op == OP_CONFIG) || (cmd_i.op == OP_READ))
              && ({20'd0, cmd_i.rcid} < 32'(NUM_RCID))
              && (!SPLIT_AT || (cmd_i.at <= 3'd1));
  assign done  = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      status_q <= ST_NONE;
    end else if (launch_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CMD_LAT - 1);
    end else if (done) begin
      busy_q   <= 1'b0;
      status_q <= legal ? ST_OK : ST_BAD;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign status_o   = status_q;
  assign tbl_we_o   = done && legal && (cmd_i.op == OP_CONFIG);
  assign stage_ld_o = done && legal && (cmd_i.op == OP_READ);

  assert_busy_span_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);

  assert_done_status_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (status_q != ST_NONE));

endmodule

// File: rtl/cc_mask_table.sv
module cc_mask_table #(
  parameter int unsigned NUM_RCID = 16,
  parameter int unsigned NCBLKS   = 16,
  parameter bit          SPLIT_AT = 1'b1,
  localparam int unsigned RIDX_W  = (NUM_RCID > 1) ? $clog2(NUM_RCID) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RIDX_W-1:0] idx_i,
  input  logic              half_i,
  input  logic [NCBLKS-1:0] wmask_i,
  output logic [NCBLKS-1:0] rmask_o
);

  if (SPLIT_AT) begin : g_split
    logic [NCBLKS-1:0] data_q [NUM_RCID];
    logic [NCBLKS-1:0] code_q [NUM_RCID];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < NUM_RCID; r++) begin
          data_q[r] <= '1;
          code_q[r] <= '1;
        end
      end else if (we_i) begin
        if (half_i) code_q[idx_i] <= wmask_i;
        else        data_q[idx_i] <= wmask_i;
      end
    end

    assign rmask_o = half_i ? code_q[idx_i] : data_q[idx_i];
  end else begin : g_unified
    logic [NCBLKS-1:0] mask_q [NUM_RCID];
    logic              unused_half;

    assign unused_half = half_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < NUM_RCID; r++) mask_q[r] <= '1;
      end else if (we_i) begin
        mask_q[idx_i] <= wmask_i;
      end
    end

    assign rmask_o = mask_q[idx_i];
  end

endmodule

// File: rtl/cc_alloc_ctrl.sv
module cc_alloc_ctrl
  import cc_alloc_pkg::*;
#(
  parameter int unsigned NUM_RCID  = 16,
  parameter int unsigned NCBLKS    = 16,
  parameter bit          SPLIT_AT  = 1'b1,
  parameter int unsigned CMD_LAT   = 4,
  parameter int unsigned VER_MAJOR = 1,
  parameter int unsigned VER_MINOR = 0,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o
);

  localparam int unsigned RIDX_W = (NUM_RCID > 1) ? $clog2(NUM_RCID) : 1;
  localparam logic [63:0] CAPS_WORD = {40'd0, 16'(NCBLKS), 4'(VER_MAJOR), 4'(VER_MINOR)};

  logic              hit_caps, hit_ctl, hit_stage;
  logic              wr_ctl, wr_stage, launch;
  logic [4:0]        op_q;
  logic [2:0]        at_q;
  logic [11:0]       rcid_q;
  logic [11:0]       keep_lo_q;
  logic [23:0]       keep_hi_q;
  logic [NCBLKS-1:0] stage_q;
  logic [NCBLKS-1:0] tbl_rmask;
  logic              busy, tbl_we, stage_ld;
  logic [6:0]        status;
  logic [7:0]        unused_wd;
  cmd_t              cmd;

  assign unused_wd = wdata_i[39:32];

  assign hit_caps  = (addr_i == ADDR_W'(OFF_CAPS));
  assign hit_ctl   = (addr_i == ADDR_W'(OFF_CTL));
  assign hit_stage = (addr_i == ADDR_W'(OFF_STAGE));

  assign wr_ctl   = req_i && we_i && hit_ctl && !busy;
  assign wr_stage = req_i && we_i && hit_stage && !busy;
  assign launch   = wr_ctl && (wdata_i[4:0] != OP_NOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= '0;
      at_q      <= '0;
      rcid_q    <= '0;
      keep_lo_q <= '0;
      keep_hi_q <= '0;
    end else if (wr_ctl) begin
      op_q      <= wdata_i[4:0];
      at_q      <= SPLIT_AT ? wdata_i[7:5] : 3'd0;
      rcid_q    <= wdata_i[19:8];
      keep_lo_q <= wdata_i[31:20];
      keep_hi_q <= wdata_i[63:40];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stage_q <= '0;
    else if (stage_ld) stage_q <= tbl_rmask;
    else if (wr_stage) stage_q <= wdata_i[NCBLKS-1:0];
  end

  assign cmd = '{rcid: rcid_q, at: at_q, op: op_q};

  cc_cmd_fsm #(
    .CMD_LAT (CMD_LAT),
    .NUM_RCID(NUM_RCID),
    .SPLIT_AT(SPLIT_AT)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .cmd_i     (cmd),
    .busy_o    (busy),
    .status_o  (status),
    .tbl_we_o  (tbl_we),
    .stage_ld_o(stage_ld)
  );

  cc_mask_table #(
    .NUM_RCID(NUM_RCID),
    .NCBLKS  (NCBLKS),
    .SPLIT_AT(SPLIT_AT)
  ) i_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (tbl_we),
    .idx_i  (rcid_q[RIDX_W-1:0]),
    .half_i (SPLIT_AT ? at_q[0] : 1'b0),
    .wmask_i(stage_q),
    .rmask_o(tbl_rmask)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (hit_caps)       rdata_o = CAPS_WORD;
      else if (hit_ctl)   rdata_o = {keep_hi_q, busy, status, keep_lo_q, rcid_q, at_q, op_q};
      else if (hit_stage) rdata_o = 64'(stage_q);
    end
  end

  assert_ctl_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && req_i && we_i && hit_ctl) |=> ($stable(op_q) && $stable(rcid_q) && $stable(at_q)));

  assert_stage_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !stage_ld && req_i && we_i && hit_stage) |=> $stable(stage_q));

  assert_cfg_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we |-> (busy && op_q == OP_CONFIG && {20'd0, rcid_q} < 32'(NUM_RCID)));

  assert_nop_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && req_i && we_i && hit_ctl && wdata_i[4:0] == OP_NOP) |=> !busy);

endmodule

// File: tb/test_cc_alloc_ctrl.sv
`timescale 1ns/1ps
module test_cc_alloc_ctrl;

  localparam int NR_A = 16, NC_A = 20, LAT_A = 4;
  localparam int NR_B = 5,  NC_B = 8,  LAT_B = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sel = 1'b0;
  logic [5:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata_a, rdata_b, rdata;

  int nchk = 0, nfail = 0;

  int          cur_nr, cur_nc, cur_lat;
  bit          cur_split;
  logic [31:0] m_tbl [2][16];
  logic [63:0] m_stage;
  logic [6:0]  m_status;

  always #5 clk = ~clk;

  cc_alloc_ctrl #(.NUM_RCID(NR_A), .NCBLKS(NC_A), .SPLIT_AT(1'b1), .CMD_LAT(LAT_A)) i_cc_alloc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req && !sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_a));

  cc_alloc_ctrl #(.NUM_RCID(NR_B), .NCBLKS(NC_B), .SPLIT_AT(1'b0), .CMD_LAT(LAT_B)) i_cc_alloc_ctrl_unified (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req && sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_b));

  assign rdata = sel ? rdata_b : rdata_a;

  function automatic logic [63:0] full_mask(int nc);
    return (64'd1 << nc) - 64'd1;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic peek(logic [5:0] a, output logic [63:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [63:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic wait_idle(output int n);
    logic [63:0] v;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      peek(6'h18, v);
      if (!v[39]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic stage_wr(logic [63:0] d);
    logic [63:0] v;
    bus_wr(6'h20, d);
    m_stage = d & full_mask(cur_nc);
    peek(6'h20, v);
    chk("R10 staging masked", v, m_stage);
  endtask

  task automatic cmd(logic [4:0] op, logic [2:0] at, logic [11:0] rcid);
    logic [23:0] hi;
    logic [11:0] lo;
    logic [63:0] v, exp;
    int n;
    bit legal;
    int half;
    hi = 24'($urandom);
    lo = 12'($urandom);
    bus_wr(6'h18, {hi, 8'($urandom), lo, rcid, at, op});
    if (op == 5'd0) begin
      peek(6'h18, v);
      chk("R8 nop no busy", 64'(v[39]), 64'd0);
    end else begin
      wait_idle(n);
      chk("R5 busy cycles", 64'(n), 64'(cur_lat));
      legal = (op == 5'd1 || op == 5'd2) && (int'(rcid) < cur_nr) && (!cur_split || at <= 3'd1);
      half = cur_split ? int'(at[0]) : 0;
      if (legal && op == 5'd1) m_tbl[half][rcid] = m_stage[31:0];
      if (legal && op == 5'd2) m_stage = 64'(m_tbl[half][rcid]);
      m_status = legal ? 7'd1 : 7'd2;
    end
    peek(6'h18, v);
    exp = {hi, 1'b0, m_status, lo, rcid, cur_split ? at : 3'd0, op};
    chk("R2 R3 R7 R9 control readback", v, exp);
    peek(6'h20, v);
    chk("R4 R7 staging after command", v, m_stage);
  endtask

  task automatic run_phase(bit s, int nr, int nc, int lat, bit split);
    logic [63:0] v;
    logic [63:0] pat_a, pat_b;
    int n;
    sel = s; cur_nr = nr; cur_nc = nc; cur_lat = lat; cur_split = split;
    for (int h = 0; h < 2; h++)
      for (int r = 0; r < 16; r++) m_tbl[h][r] = full_mask(nc);
    m_stage = '0; m_status = '0;

    bus_rd(6'h00, v);
    chk("R1 capabilities", v, {40'd0, 16'(nc), 4'd1, 4'd0});
    bus_rd(6'h18, v);
    chk("R5 control after reset", v, 64'd0);
    bus_rd(6'h20, v);
    chk("R11 staging after reset", v, 64'd0);
    bus_rd(6'h08, v); chk("R12 offset 08", v, 64'd0);
    bus_rd(6'h10, v); chk("R12 offset 10", v, 64'd0);
    bus_rd(6'h28, v); chk("R12 offset 28", v, 64'd0);

    // R11: reset entries read as all ones
    for (int h = 0; h < 2; h++) begin
      cmd(5'd2, 3'(h), 12'd0);
      chk("R11 entry 0", m_stage, full_mask(nc));
      cmd(5'd2, 3'(h), 12'(nr - 1));
    end

    bus_wr(6'h00, '1);
    bus_rd(6'h00, v);
    chk("R1 capabilities write ignored", v, {40'd0, 16'(nc), 4'd1, 4'd0});

    stage_wr('1);
    chk("R10 upper staging zero", m_stage, full_mask(nc));

    // R9: separate halves vs shared mask
    stage_wr(64'h0000_0000_0005_A5A5);
    cmd(5'd1, 3'd0, 12'd3);
    stage_wr(64'h0000_0000_000C_3C3C);
    cmd(5'd1, 3'd1, 12'd3);
    stage_wr(64'd0);
    cmd(5'd2, 3'd0, 12'd3);
    chk("R9 data half view", m_stage,
        (split ? 64'h5A5A5 : 64'hC3C3C) & full_mask(nc));

    // R7: illegal parameters leave state alone
    cmd(5'd1, 3'd0, 12'(nr));
    cmd(5'd3, 3'd0, 12'd3);
    cmd(5'd31, 3'd0, 12'd3);
    if (split) cmd(5'd1, 3'd2, 12'd3);
    cmd(5'd2, 3'd0, 12'd3);

    // R8: nop keeps status
    cmd(5'd0, 3'd1, 12'd2);

    // R6: writes during busy are dropped
    if (lat >= 3) begin
      pat_a = 64'h0000_0000_0001_2345;
      pat_b = 64'h0000_0000_000F_EDCB;
      stage_wr(pat_a);
      bus_wr(6'h18, {24'd0, 8'd0, 12'd0, 12'd1, 3'd0, 5'd1});
      bus_wr(6'h20, pat_b);
      bus_wr(6'h18, {24'hFFFFFF, 8'd0, 12'hFFF, 12'd2, 3'd1, 5'd2});
      wait_idle(n);
      m_tbl[0][1] = pat_a[31:0] & 32'(full_mask(nc));
      m_status = 7'd1;
      peek(6'h18, v);
      chk("R6 control held", v, {24'd0, 1'b0, 7'd1, 12'd0, 12'd1, 3'd0, 5'd1});
      peek(6'h20, v);
      chk("R6 staging held", v, m_stage);
      stage_wr(64'd0);
      cmd(5'd2, 3'd0, 12'd1);
      chk("R6 R3 table loaded", m_stage, pat_a & full_mask(nc));
    end

    for (int i = 0; i < 250; i++) begin
      logic [4:0] op;
      case ($urandom % 8)
        0: op = 5'd0;
        1, 2, 3: op = 5'd1;
        4, 5, 6: op = 5'd2;
        default: op = 5'($urandom);
      endcase
      if ($urandom % 3 == 0) stage_wr({$urandom, $urandom});
      cmd(op, 3'($urandom % 3), 12'($urandom % (nr + 3)));
    end
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_phase(1'b0, NR_A, NC_A, LAT_A, 1'b1);
    run_phase(1'b1, NR_B, NC_B, LAT_B, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R5: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule